// File: doc/BRIEF.md
# Multi-Thread Timed Gate Scheduler

This block opens and closes the egress gates of a group of switch ports, one gate per traffic class, by following a time-triggered schedule. A single linear table of timeslots holds the schedule for every thread. Each timeslot carries three fields: a duration, a mask of the ports it drives, and a mask of the traffic-class gates it closes. Up to eight execution threads share this table. Each thread owns a contiguous index range of the table and walks it cyclically. Each thread also has an entry offset, which it adds to a common base time to get its own start time.

Software fills the tables through one write port, sets the base time, and then issues a start command. From that point the engine is armed. It begins running when the supplied PTP time reaches the base time, and each thread joins once its own start time has passed. A stop command returns every gate to open. Two status flags report whether the engine is running or stopped. The scheduler advances by one tick per clock, and a duration unit is a fixed number of ticks (25 by default).

Top module: `gcl_engine`

## Requirements
- R1: After reset the engine is stopped: `sched_stopped`=1, `sched_running`=0, and every bit of `gate_open` is 1.
- R2: A `cmd_start` pulse while the engine is stopped arms it. While armed, both flags are 0 and all gates are open. On the first clock where `ptp_time` >= base time, the engine enters running (`sched_running`=1). It stays running until `cmd_stop`, and the two flags are never both 1.
- R3: Thread i becomes active on the first clock where the engine is armed or running and `ptp_time` >= base + offset_i × TPU, with TPU = 25 ticks. A time that is already past the threshold when the engine arms also qualifies. On activation the thread selects its start address.
- R4: A timeslot with duration d stays selected for exactly d × TPU clocks. A duration of 0 counts as 1.
- R5: After the timeslot at its end index, a thread returns to its start address and repeats the range.
- R6: `gate_open[p*8 +: 8]` for port p equals the complement of the closed-gate mask of the timeslot an active thread currently selects, provided that timeslot's port mask has bit p set. A port that no active thread addresses has all 8 gates open.
- R7: When several active threads address the same port, the thread with the highest index decides that port's gates.
- R8: Threads whose index is above the programmed last-active index never activate and have no effect on any gate.
- R9: A `cmd_stop` pulse takes priority over start. On the next clock it deactivates every thread, sets `sched_stopped`=1 and `sched_running`=0, and opens all gates.
- R10: The write port decodes `wr_kind` as follows:
  - 0 writes timeslot `wr_addr` with `{duration[21:12], port mask[11:8], closed mask[7:0]}`.
  - 1 writes the entry point of thread `wr_addr[2:0]` with start address in [3:0] and offset in [15:4].
  - 2 writes the end index of thread `wr_addr[2:0]` from [3:0].
  - 3 with `wr_addr` 0 writes the base time from [31:0]; 3 with `wr_addr` 1 writes the last-active index from [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one scheduler tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptp_time | input | 32 | Current PTP time in ticks |
| cmd_start | input | 1 | Arm the schedule (pulse) |
| cmd_stop | input | 1 | Halt the schedule (pulse) |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Write target selector |
| wr_addr | input | 4 | Timeslot, thread or global register index |
| wr_data | input | 32 | Write data |
| gate_open | output | 32 | Open flag per port (4) and traffic class (8) |
| sched_running | output | 1 | Schedule is running |
| sched_stopped | output | 1 | Schedule is stopped |

## Verification
The bench samples the gates at the exact tick on either side of each thread's start threshold. An off-by-one in the comparison, or a thread that only fires on an exact time match, would open or close a gate one tick late or not at all. Slot boundaries are checked at both their first and last tick, and at the wrap from the end index back to the start address. A miscounted duration would shift every later edge, and a wrong wrap would run into a neighbour's range. The run includes a port that two threads claim at the same time, so a reversed priority shows up as the lower thread's mask. A second run lowers the last-active index and arms with the base time already in the past, which catches a disabled thread that still drives gates and a start that waits for an exact time match.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ARMED = 2'd1,
    ENG_RUN   = 2'd2
  } eng_state_t;

  typedef enum logic [1:0] {
    WK_SLOT   = 2'd0,
    WK_ENTRY  = 2'd1,
    WK_END    = 2'd2,
    WK_GLOBAL = 2'd3
  } wr_kind_t;
endpackage

// File: rtl/gcl_cfg.sv
module gcl_cfg #(
  parameter int NTHR   = 8,
  parameter int NPORT  = 4,
  parameter int NTC    = 8,
  parameter int DEPTH  = 16,
  parameter int DUR_W  = 10,
  parameter int OFS_W  = 12,
  parameter int TIME_W = 32,
  parameter int WR_W   = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int TW     = $clog2(NTHR),
  localparam int SLOT_W = DUR_W + NPORT + NTC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  output logic [SLOT_W-1:0] slot_q [DEPTH],
  output logic [AW-1:0]     first_q [NTHR],
  output logic [OFS_W-1:0]  ofs_q [NTHR],
  output logic [AW-1:0]     last_idx_q [NTHR],
  output logic [TIME_W-1:0] base_q,
  output logic [TW-1:0]     top_thr_q
);
  import gcl_pkg::*;

  logic we_base, we_top;
  assign we_base = wr_en && (wr_kind == WK_GLOBAL) && (wr_addr == AW'(0));
  assign we_top  = wr_en && (wr_kind == WK_GLOBAL) && (wr_addr == AW'(1));

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic we;
    assign we = wr_en && (wr_kind == WK_SLOT) && (wr_addr == AW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[k] <= '0;
      else if (we) slot_q[k] <= wr_data[SLOT_W-1:0];
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic we_ep, we_end;
    assign we_ep  = wr_en && (wr_kind == WK_ENTRY) && (wr_addr[TW-1:0] == TW'(t));
    assign we_end = wr_en && (wr_kind == WK_END)   && (wr_addr[TW-1:0] == TW'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        first_q[t] <= '0;
        ofs_q[t]   <= '0;
      end else if (we_ep) begin
        first_q[t] <= wr_data[AW-1:0];
        ofs_q[t]   <= wr_data[AW +: OFS_W];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_idx_q[t] <= '0;
      else if (we_end) last_idx_q[t] <= wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (we_base) base_q <= wr_data[TIME_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_thr_q <= '0;
    else if (we_top) top_thr_q <= wr_data[TW-1:0];
  end
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread #(
  parameter int AW     = 4,
  parameter int DUR_W  = 10,
  parameter int OFS_W  = 12,
  parameter int TIME_W = 32,
  parameter int TPU    = 25,
  localparam int CNT_W = DUR_W + $clog2(TPU + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              valid,
  input  logic [TIME_W-1:0] ptp_time,
  input  logic [TIME_W-1:0] base_time,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [AW-1:0]     first_idx,
  input  logic [AW-1:0]     last_idx,
  input  logic [DUR_W-1:0]  cur_dur,
  output logic              act_q,
  output logic [AW-1:0]     idx_q
);
  logic [TIME_W-1:0] start_at;
  logic [CNT_W-1:0]  slot_len, cnt_q, cnt_d;
  logic              slot_end, go, act_d;
  logic [AW-1:0]     idx_d;

  assign start_at = base_time + TIME_W'(ofs) * TIME_W'(TPU);
  assign go       = ptp_time >= start_at;
  assign slot_len = CNT_W'(cur_dur) * CNT_W'(TPU);
  assign slot_end = (cur_dur == '0) ? (cnt_q >= CNT_W'(TPU - 1))
                                    : (cnt_q >= slot_len - CNT_W'(1));

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (!en || !valid) begin
      act_d = 1'b0;
      idx_d = '0;
      cnt_d = '0;
    end else if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        idx_d = first_idx;
        cnt_d = '0;
      end
    end else if (slot_end) begin
      cnt_d = '0;
      idx_d = (idx_q == last_idx) ? first_idx : idx_q + AW'(1);
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/gcl_merge.sv
module gcl_merge #(
  parameter int NTHR  = 8,
  parameter int NPORT = 4,
  parameter int NTC   = 8
) (
  input  logic                   act [NTHR],
  input  logic [NPORT-1:0]       pmask [NTHR],
  input  logic [NTC-1:0]         closed [NTHR],
  output logic [NPORT*NTC-1:0]   gate_open
);
  // Ascending walk: a later (higher) thread overwrites an earlier one.
  always_comb begin
    gate_open = '1;
    for (int p = 0; p < NPORT; p++) begin
      for (int t = 0; t < NTHR; t++) begin
        if (act[t] && pmask[t][p]) gate_open[p*NTC +: NTC] = ~closed[t];
      end
    end
  end
endmodule

// File: rtl/gcl_engine.sv
module gcl_engine #(
  parameter int NTHR   = 8,
  parameter int NPORT  = 4,
  parameter int NTC    = 8,
  parameter int DEPTH  = 16,
  parameter int DUR_W  = 10,
  parameter int OFS_W  = 12,
  parameter int TIME_W = 32,
  parameter int WR_W   = 32,
  parameter int TPU    = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TIME_W-1:0]         ptp_time,
  input  logic                      cmd_start,
  input  logic                      cmd_stop,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [$clog2(DEPTH)-1:0]  wr_addr,
  input  logic [WR_W-1:0]           wr_data,
  output logic [NPORT*NTC-1:0]      gate_open,
  output logic                      sched_running,
  output logic                      sched_stopped
);
  import gcl_pkg::*;

  localparam int AW     = $clog2(DEPTH);
  localparam int TW     = $clog2(NTHR);
  localparam int SLOT_W = DUR_W + NPORT + NTC;
  localparam int GW     = NPORT * NTC;

  logic [SLOT_W-1:0] slot_q [DEPTH];
  logic [AW-1:0]     first_q [NTHR];
  logic [OFS_W-1:0]  ofs_q [NTHR];
  logic [AW-1:0]     last_idx_q [NTHR];
  logic [TIME_W-1:0] base_q;
  logic [TW-1:0]     top_thr_q;

  gcl_cfg #(
    .NTHR(NTHR), .NPORT(NPORT), .NTC(NTC), .DEPTH(DEPTH), .DUR_W(DUR_W),
    .OFS_W(OFS_W), .TIME_W(TIME_W), .WR_W(WR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_addr(wr_addr), .wr_data(wr_data), .slot_q(slot_q),
    .first_q(first_q), .ofs_q(ofs_q), .last_idx_q(last_idx_q),
    .base_q(base_q), .top_thr_q(top_thr_q)
  );

  eng_state_t state_q, state_d;
  logic       thr_en;

  always_comb begin
    state_d = state_q;
    if (cmd_stop) begin
      state_d = ENG_IDLE;
    end else begin
      case (state_q)
        ENG_IDLE:  if (cmd_start) state_d = ENG_ARMED;
        ENG_ARMED: if (ptp_time >= base_q) state_d = ENG_RUN;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ENG_IDLE;
    else        state_q <= state_d;
  end

  assign thr_en        = (state_q != ENG_IDLE) && !cmd_stop;
  assign sched_running = (state_q == ENG_RUN);
  assign sched_stopped = (state_q == ENG_IDLE);

  logic             act [NTHR];
  logic [AW-1:0]    idx [NTHR];
  logic [NPORT-1:0] pmask [NTHR];
  logic [NTC-1:0]   closed [NTHR];

  for (genvar i = 0; i < NTHR; i++) begin : g_thread
    logic [SLOT_W-1:0] cur;
    assign cur       = slot_q[idx[i]];
    assign pmask[i]  = cur[NTC +: NPORT];
    assign closed[i] = cur[NTC-1:0];

    gcl_thread #(
      .AW(AW), .DUR_W(DUR_W), .OFS_W(OFS_W), .TIME_W(TIME_W), .TPU(TPU)
    ) u_thr (
      .clk(clk), .rst_n(rst_n), .en(thr_en),
      .valid(TW'(i) <= top_thr_q),
      .ptp_time(ptp_time), .base_time(base_q), .ofs(ofs_q[i]),
      .first_idx(first_q[i]), .last_idx(last_idx_q[i]),
      .cur_dur(cur[NTC+NPORT +: DUR_W]),
      .act_q(act[i]), .idx_q(idx[i])
    );
  end

  gcl_merge #(.NTHR(NTHR), .NPORT(NPORT), .NTC(NTC)) u_merge (
    .act(act), .pmask(pmask), .closed(closed), .gate_open(gate_open)
  );
endmodule

// File: rtl/gcl_engine_chk.sv
module gcl_engine_chk #(
  parameter int TIME_W = 32,
  parameter int GW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_stop,
  input logic [TIME_W-1:0] ptp_time,
  input logic [TIME_W-1:0] base_q,
  input logic [GW-1:0]     gate_open,
  input logic              sched_running,
  input logic              sched_stopped
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sched_running && sched_stopped)); // R2
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_stop && sched_stopped) |=> !sched_stopped); // R2
  AST_RUN_AFTER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sched_running) |-> ($past(ptp_time) >= $past(base_q))); // R2
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_running && !cmd_stop) |=> sched_running); // R2
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (sched_stopped && !sched_running)); // R9
  AST_STOPPED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    sched_stopped |-> (&gate_open)); // R9
endmodule

bind gcl_engine gcl_engine_chk #(.TIME_W(TIME_W), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .ptp_time(ptp_time), .base_q(base_q), .gate_open(gate_open),
  .sched_running(sched_running), .sched_stopped(sched_stopped)
);

// File: tb/gcl_engine_bench.sv
`timescale 1ns/1ps
module gcl_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptp_time = '0;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] gate_open;
  logic        sched_running, sched_stopped;

  int n_tests = 0, n_fail = 0;
  logic [31:0] s_edge;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) ptp_time <= '0;
    else        ptp_time <= ptp_time + 32'd1;
  end

  gcl_engine u_gcl_engine (
    .clk(clk), .rst_n(rst_n), .ptp_time(ptp_time), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_open(gate_open), .sched_running(sched_running),
    .sched_stopped(sched_stopped)
  );

  // {ptp value after whose edge to sample, expected gate_open}
  localparam logic [63:0] VEC [11] = '{
    {32'd1000, 32'hFFFF_FFFF}, {32'd1024, 32'hFFFF_FFFF},
    {32'd1025, 32'hFFFF_F0F0}, {32'd1049, 32'hFFFF_F0F0},
    {32'd1050, 32'hFF55_550F}, {32'd1099, 32'hFF55_550F},
    {32'd1100, 32'hFF55_55F0}, {32'd1124, 32'hFF55_55F0},
    {32'd1125, 32'hFF55_550F}, {32'd1174, 32'hFF55_550F},
    {32'd1175, 32'hFF55_55F0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (ptp %0d)", req, act, exp, ptp_time);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ptp(input logic [31:0] v);
    do @(posedge clk); while (ptp_time != v);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk); cmd_start = 1'b1;
    @(posedge clk); s_edge = ptp_time;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 stopped flag", {31'd0, sched_stopped}, 32'd1);
    chk("R1 running flag", {31'd0, sched_running}, 32'd0);
    chk("R1 gates open", gate_open, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    // R10 configuration through the write port
    wr(2'd0, 4'd0, 32'h130F);  // dur 1, ports 0,1, close 0x0F
    wr(2'd0, 4'd1, 32'h21F0);  // dur 2, port 0, close 0xF0
    wr(2'd0, 4'd2, 32'h16AA);  // dur 1, ports 1,2, close 0xAA
    wr(2'd1, 4'd0, 32'h10);    // thread0 start 0, offset 1
    wr(2'd1, 4'd1, 32'h22);    // thread1 start 2, offset 2
    wr(2'd2, 4'd0, 32'd1);
    for (int t = 1; t < 8; t++) wr(2'd2, 4'(t), 32'd2);
    wr(2'd3, 4'd0, 32'd1000);
    wr(2'd3, 4'd1, 32'd1);
    pulse_start();
    wait_ptp(32'd999);
    chk("R2 armed not running", {31'd0, sched_running}, 32'd0);
    chk("R2 armed not stopped", {31'd0, sched_stopped}, 32'd0);
    chk("R2 armed gates open", gate_open, 32'hFFFF_FFFF);
    for (int i = 0; i < 11; i++) begin
      wait_ptp(VEC[i][63:32]);
      chk("R3 R4 R5 R6 R7 gate vector", gate_open, VEC[i][31:0]);
      if (i == 0) chk("R2 running at base", {31'd0, sched_running}, 32'd1);
    end
    // R9 stop
    @(negedge clk); cmd_stop = 1'b1;
    @(posedge clk); #1;
    chk("R9 stopped", {31'd0, sched_stopped}, 32'd1);
    chk("R9 not running", {31'd0, sched_running}, 32'd0);
    chk("R9 gates open", gate_open, 32'hFFFF_FFFF);
    @(negedge clk); cmd_stop = 1'b0;
    // R8 only thread0 enabled; base already in the past (R3 >= compare)
    wr(2'd3, 4'd1, 32'd0);
    wr(2'd3, 4'd0, 32'd1100);
    pulse_start();
    wait_ptp(s_edge + 32'd1);
    chk("R3 late start thread0 slot0", gate_open, 32'hFFFF_F0F0);
    chk("R2 running late", {31'd0, sched_running}, 32'd1);
    wait_ptp(s_edge + 32'd26);
    chk("R8 thread1 ignored", gate_open, 32'hFFFF_FF0F);
    wait_ptp(s_edge + 32'd76);
    chk("R5 wrap to start", gate_open, 32'hFFFF_F0F0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule